// File: doc/BRIEF.md
# Flow-Through Synchronous SRAM Core with Zero-Turnaround Write Pipeline

This block is a single-port synchronous memory with byte lanes. It accepts a new read or write command on every rising clock edge, so reads and writes can be mixed in any order with no idle cycles. Address and command are registered at the edge. Read data then comes straight out of the array through combinational logic, in the cycle that follows the command edge, with no output register. Write data trails its command by one enabled edge. A one-entry pending-write stage holds that data until the next enabled edge commits it, and a read that hits the pending entry gets the new bytes merged over the stored word.

A pipeline with a shared bidirectional data bus is modelled with separate `wdata`, `rdata` and `drive_en` signals. `drive_en` tells an outer pad ring when the core would drive the bus. It goes low in every write data phase, in every deselected cycle, and at once whenever `out_en` is low. The core has no valid/ready handshake. `clk_en` is the only stall: when it is low the whole pipeline holds, no command is taken, and the current output cycle is stretched. Bursts of four beats cover the two low address bits, in linear or interleaved order.

Top module: `ftsram_core`

## Requirements
- R1: While reset is active and right after it, `drive_en` is 0 even with `out_en` high, and no write is pending.
- R2: A read command (load with `wr_en`=0, all enables asserted) registered at an enabled edge drives `rdata` with the addressed word, and `drive_en`=1 when `out_en`=1, in the cycle after that edge.
- R3: The data and `byte_sel` of a write are sampled at the next enabled edge after the write command. Only the lanes whose `byte_sel` bit is 1 are updated, where bit i covers `wdata[9*i+8:9*i]`.
- R4: A read returns the newest data for its address, including bytes whose data arrived at the same edge as the read command, for any mix of reads and writes on consecutive edges.
- R5: A load is taken only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Otherwise the cycle is a deselect: `drive_en`=0 in the next cycle and the memory is not written.
- R6: When `clk_en`=0 no register changes. The outputs hold, and the command, data and burst inputs of that edge are ignored.
- R7: `drive_en` is 0 in the cycle that follows a write command edge, which is the write data phase.
- R8: `out_en`=0 forces `drive_en` to 0 at once, with no clock edge.
- R9: With `order_ilv`=0 at load, each `adv` cycle steps the two low address bits by +1 modulo 4. The upper bits stay fixed.
- R10: With `order_ilv`=1 at load, beat k addresses the low bits start XOR k.
- R11: `adv`=1 continues the current burst with the direction of the last load and ignores `wr_en` and the chip enables. After a deselect, `adv` keeps the core deselected.
- R12: Write data arriving in a deselect cycle is still committed to the addressed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Active-high clock qualifier; low holds the pipeline |
| adv | input | 1 | 1 = advance current burst, 0 = load a new command |
| addr | input | 8 | Word address for a load |
| wr_en | input | 1 | 1 = write, 0 = read (load only) |
| byte_sel | input | 4 | Per-lane write selects, sampled in the write data phase |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en | input | 1 | Asynchronous output enable, active high |
| wdata | input | 36 | Write data, one enabled edge after the write command |
| rdata | output | 36 | Flow-through read data |
| drive_en | output | 1 | High when the core would drive the shared bus |

## Verification
The expected results fall on three timings. Read data and `drive_en` follow in the cycle right after the enabled edge that took the command. Write data lands at the next enabled edge and can be read from that same edge. `out_en` has its effect without any edge. The bench applies inputs 1 ns after a rising edge. At each edge it moves a reference model forward by one enabled step, and 1 ns later it compares `drive_en`, and `rdata` whenever a read is due. So every check sits in the cycle where its result is defined. The `out_en` checks are taken between edges after a short delay.

// File: rtl/ftsram_pkg.sv
package ftsram_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  // Low address bits of a burst beat.
  function automatic logic [BEAT_W-1:0] burst_lo(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_ord_e        ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ beat;
    return BEAT_W'(start + beat);
  endfunction
endpackage

// File: rtl/ftsram_burst_seq.sv
module ftsram_burst_seq
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ilv_in,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  burst_ord_e        ord_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld <= 1'b0;
      cmd_wr  <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_LINEAR;
    end else if (clk_en) begin
      if (adv) begin
        if (cmd_vld) beat_q <= beat_q + 1'b1;
      end else if (sel_ok) begin
        cmd_vld <= 1'b1;
        cmd_wr  <= wr_req;
        base_q  <= addr_in;
        beat_q  <= '0;
        ord_q   <= ilv_in ? ORD_INTERLEAVE : ORD_LINEAR;
      end else begin
        cmd_vld <= 1'b0;
      end
    end
  end

  assign cmd_addr = {base_q[ADDR_W-1:BEAT_W],
                     burst_lo(base_q[BEAT_W-1:0], beat_q, ord_q)};

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cmd_addr) && $stable(cmd_vld) && $stable(cmd_wr)); // R6
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && cmd_vld && ord_q == ORD_LINEAR |=>
      cmd_addr[BEAT_W-1:0] == BEAT_W'($past(cmd_addr[BEAT_W-1:0]) + 1'b1)
      && cmd_addr[ADDR_W-1:BEAT_W] == $past(cmd_addr[ADDR_W-1:BEAT_W])); // R9
  AST_ILV_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && cmd_vld && ord_q == ORD_INTERLEAVE && beat_q == '0 |=>
      cmd_addr[0] != $past(cmd_addr[0]) && cmd_addr[1] == $past(cmd_addr[1])); // R10
  AST_ADV_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && cmd_vld |=> cmd_vld && $stable(cmd_wr)); // R11
  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && adv && !cmd_vld |=> !cmd_vld); // R11
endmodule

// File: rtl/ftsram_late_write.sv
module ftsram_late_write
  import ftsram_pkg::*;
#(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [LANES-1:0]  cap_be,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic [LANES-1:0]  commit_be,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic [LANES-1:0]  pend_be;
  logic              hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else if (clk_en) begin
      pend_vld <= cap_en;
      if (cap_en) begin
        pend_addr <= cap_addr;
        pend_data <= cap_data;
        pend_be   <= cap_be;
      end
    end
  end

  assign commit_en   = clk_en & pend_vld;
  assign commit_addr = pend_addr;
  assign commit_data = pend_data;
  assign commit_be   = pend_be;

  assign hit = pend_vld && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign rd_data[g*LANE_W +: LANE_W] = (hit && pend_be[g])
      ? pend_data[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  AST_DATA_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && cap_en |=> pend_vld && pend_addr == $past(cap_addr)); // R3
  AST_NO_STRAY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !cap_en |=> !pend_vld); // R3
endmodule

// File: rtl/ftsram_array.sv
module ftsram_array #(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/ftsram_core.sv
module ftsram_core
  import ftsram_pkg::*;
#(
  parameter  int ADDR_W = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [LANES-1:0]  byte_sel,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              order_ilv,
  input  logic              out_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              drive_en
);
  logic              chip_ok;
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [LANES-1:0]  commit_be;
  logic [DATA_W-1:0] arr_data;

  assign chip_ok = !ce_a_n && ce_b && !ce_c_n;

  ftsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv),
    .sel_ok(chip_ok), .wr_req(wr_en), .addr_in(addr), .ilv_in(order_ilv),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr)
  );

  ftsram_late_write #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lw (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .cap_en(cmd_vld & cmd_wr), .cap_addr(cmd_addr), .cap_data(wdata),
    .cap_be(byte_sel),
    .commit_en(commit_en), .commit_addr(commit_addr),
    .commit_data(commit_data), .commit_be(commit_be),
    .rd_addr(cmd_addr), .arr_data(arr_data), .rd_data(rdata)
  );

  ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .we(commit_en), .waddr(commit_addr), .wbe(commit_be),
    .wdata(commit_data), .raddr(cmd_addr), .rdata(arr_data)
  );

  assign drive_en = out_en & cmd_vld & ~cmd_wr;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv && !chip_ok |=> !drive_en); // R5
  AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv && chip_ok && wr_en |=> !drive_en); // R7
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && !adv && chip_ok && !wr_en && out_en |=> drive_en || !out_en); // R2
endmodule

// File: tb/ftsram_core_tb_top.sv
`timescale 1ns/1ps
module ftsram_core_tb_top;
  localparam int ADDR_W = 8;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DATA_W = 36;
  localparam int DEPTH  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1, adv = 1'b0, wr_en = 1'b0, order_ilv = 1'b0, out_en = 1'b1;
  logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [LANES-1:0]  byte_sel = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              drive_en;

  int  vectors = 0, miscompares = 0;
  bit  done = 0;

  // reference model
  logic [DATA_W-1:0] mem_m [DEPTH];
  bit m_vld = 0, m_wr = 0, m_ilv = 0;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0] m_beat = '0;

  always #2.5 clk = ~clk;

  ftsram_core dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv(adv), .addr(addr),
    .wr_en(wr_en), .byte_sel(byte_sel), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .order_ilv(order_ilv), .out_en(out_en), .wdata(wdata),
    .rdata(rdata), .drive_en(drive_en)
  );

  function automatic logic [ADDR_W-1:0] m_addr();
    logic [1:0] lo;
    lo = m_ilv ? (m_base[1:0] ^ m_beat) : 2'(m_base[1:0] + m_beat);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
      input logic [DATA_W-1:0] new_w, input logic [LANES-1:0] be);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] fill_val(input int i);
    return {4'hA, i[7:0], ~i[7:0], i[7:0], ~i[7:0]};
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin m_vld = 0; m_wr = 0; return; end
    if (!clk_en) return;
    if (m_vld && m_wr) mem_m[m_addr()] = merge(mem_m[m_addr()], wdata, byte_sel);
    if (adv) begin
      if (m_vld) m_beat = m_beat + 2'd1;
    end else if (!ce_a_n && ce_b && !ce_c_n) begin
      m_vld = 1; m_wr = wr_en; m_base = addr; m_beat = '0; m_ilv = order_ilv;
    end else begin
      m_vld = 0;
    end
  endtask

  task automatic compare(input string tag);
    logic exp_drv;
    exp_drv = out_en & m_vld & ~m_wr;
    check(tag, DATA_W'(drive_en), DATA_W'(exp_drv));
    if (exp_drv) check(tag, rdata, mem_m[m_addr()]);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic chips(input bit ok);
    ce_a_n = !ok; ce_b = ok; ce_c_n = !ok;
  endtask

  task automatic ld(input bit wr, input logic [ADDR_W-1:0] a, input bit ilv);
    adv = 0; chips(1); wr_en = wr; addr = a; order_ilv = ilv;
  endtask

  task automatic wdat(input logic [DATA_W-1:0] d, input logic [LANES-1:0] be);
    wdata = d; byte_sel = be;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    ld(0, 8'h00, 0);
    step("R1"); step("R1");
    check("R1 reset drive", DATA_W'(drive_en), '0);
    #1 rst_n = 1;
    chips(0);
    step("R1");
    check("R1 after reset", DATA_W'(drive_en), '0);

    // fill memory (R7: drive stays off during writes)
    for (int i = 0; i < DEPTH; i++) begin
      ld(1, ADDR_W'(i), 0);
      wdat(i > 0 ? fill_val(i - 1) : '0, 4'hF);
      step("R7");
    end
    chips(0); wdat(fill_val(DEPTH - 1), 4'hF);
    step("R7");

    // R2: plain reads
    ld(0, 8'd10, 0); step("R2");
    ld(0, 8'd11, 0); step("R2");
    check("R2 value", rdata, fill_val(11));

    // R3: partial write, data one edge later
    ld(1, 8'd20, 0); step("R3");
    ld(0, 8'd20, 0); wdat(36'h1_2345_6789, 4'b0101); step("R3");
    check("R3 lanes", rdata, merge(fill_val(20), 36'h1_2345_6789, 4'b0101));

    // R4: back-to-back write/read, write/write/read
    ld(1, 8'd30, 0); step("R4");
    ld(1, 8'd30, 0); wdat(36'hF_0F0F_0F0F, 4'hF); step("R4");
    ld(1, 8'd31, 0); wdat(36'h3_3333_3333, 4'b1000); step("R4");
    ld(0, 8'd30, 0); wdat(36'h7_7777_7777, 4'hF); step("R4");
    ld(0, 8'd31, 0); step("R4");

    // R5: each enable off ignores a write
    for (int k = 0; k < 3; k++) begin
      ld(1, 8'd40, 0);
      if (k == 0) ce_a_n = 1; else if (k == 1) ce_b = 0; else ce_c_n = 1;
      wdat(36'hB_BBBB_BBBB, 4'hF);
      step("R5");
      check("R5 deselect drive", DATA_W'(drive_en), '0);
    end
    ld(0, 8'd40, 0); step("R5");
    check("R5 word kept", rdata, fill_val(40));

    // R6: clock enable freeze
    ld(0, 8'd41, 0); step("R6");
    clk_en = 0; ld(1, 8'd42, 0); step("R6"); step("R6");
    check("R6 held", rdata, fill_val(41));
    clk_en = 1; step("R6");
    clk_en = 0; ld(0, 8'd43, 0); wdat(36'hD_DEAD_DEAD, 4'hF); step("R6");
    clk_en = 1; wdat(36'h6_6666_6666, 4'hF); step("R6");
    ld(0, 8'd42, 0); step("R6");
    check("R6 value", rdata, 36'h6_6666_6666);

    // R8: async output enable
    out_en = 0; #1;
    check("R8 off", DATA_W'(drive_en), '0);
    out_en = 1; #1;
    check("R8 on", DATA_W'(drive_en), 36'd1);

    // R9: linear burst from 0x45
    ld(0, 8'h45, 0); step("R9");
    adv = 1; wr_en = 1; chips(0);
    step("R9"); step("R9");
    check("R9 third beat", rdata, fill_val(8'h47));
    step("R9");
    check("R9 wrap", rdata, fill_val(8'h44));

    // R10: interleaved burst from 0x46
    ld(0, 8'h46, 1); step("R10");
    adv = 1;
    step("R10");
    check("R10 beat1", rdata, fill_val(8'h47));
    step("R10");
    check("R10 beat2", rdata, fill_val(8'h44));
    step("R10");

    // R11: write burst via adv, then adv after deselect
    ld(1, 8'h50, 0); step("R11");
    adv = 1; wr_en = 0;
    for (int b = 0; b < 4; b++) begin
      wdat(36'h1_0000_0000 + 36'(b), 4'hF); step("R11");
    end
    chips(0); adv = 0; wdat(36'h9_9999_9999, 4'hF); step("R11");
    adv = 1; chips(1); step("R11");
    check("R11 idle adv", DATA_W'(drive_en), '0);
    ld(0, 8'h52, 0); step("R11");
    check("R11 burst data", rdata, 36'h1_0000_0002);

    // R12: data arriving in deselect commits
    ld(1, 8'h60, 0); step("R12");
    chips(0); wdat(36'hC_C0C0_C0C0, 4'hF); step("R12");
    ld(0, 8'h60, 0); step("R12");
    check("R12 value", rdata, 36'hC_C0C0_C0C0);

    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      clk_en    = ($urandom_range(0, 9) != 0);
      out_en    = ($urandom_range(0, 9) != 0);
      adv       = ($urandom_range(0, 4) == 0);
      wr_en     = $urandom_range(0, 1);
      order_ilv = $urandom_range(0, 1);
      chips($urandom_range(0, 6) != 0);
      addr      = ADDR_W'($urandom_range(0, 15));
      wdat({$urandom(), 4'($urandom())}, 4'($urandom()));
      step("R4");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule